// File: doc/BRIEF.md
# Four-Point Fixed-Point Radix-2 FFT Engine

This block computes a 4-point discrete Fourier transform of complex fixed-point samples using the radix-2 decimation-in-time method. All four complex inputs are presented in parallel together with a single-cycle `start` strobe. The block captures them in bit-reversed order and passes them through two registered stages of two butterflies each. It then presents the four frequency bins in parallel together with a one-cycle `done` strobe.

Each butterfly forms `a + b*W` and `a - b*W`. The twiddle `W` is held as an integer scaled by `2^TW_FRAC`. The product is brought back to the sample scale by an arithmetic right shift of `TW_FRAC` bits. For four points the only twiddles are 1 and -j. By default these are built as a pass-through and as a swap of the real and imaginary parts with one part negated. A parameter can instead select a real constant multiplier, which gives the same results.

Every adder stage widens the word by one bit. The outputs are therefore two bits wider than the inputs and can never wrap. The results stay in their registers until the next accepted transform completes.

Top module: `fft4_dit`

## Requirements
- R1: While reset is asserted, and after it is released until the first transform completes, `done` is 0 and every output word is 0.
- R2: A `start` sampled high while the engine is idle is accepted. `done` is then high only in the cycle after the third rising edge, counting the accepting edge as the first, and it is low again after the next edge.
- R3: Bin 0 equals x0+x1+x2+x3, formed separately on the real and imaginary parts. Input k sits at bits [DW*k +: DW] of `in_re`/`in_im`, and bin k sits at bits [OW*k +: OW] of `out_re`/`out_im`. All words are two's complement.
- R4: Bin 2 equals x0-x1+x2-x3 on both parts.
- R5: Bin 1 equals (x0-x2) - j(x1-x3). Its real part is x0r-x2r+x1i-x3i and its imaginary part is x0i-x2i-x1r+x3r. The unit twiddles are scaled by 2^TW_FRAC and shifted back, so the result is exact.
- R6: Bin 3 equals (x0-x2) + j(x1-x3). Its real part is x0r-x2r-x1i+x3i and its imaginary part is x0i-x2i+x1r-x3r.
- R7: Output words are DW+2 bits wide. Full-scale inputs, including -2^(DW-1) on every part, give exact results with no wraparound.
- R8: Outputs stay unchanged, whatever happens on the inputs, until the next accepted transform delivers new results.
- R9: A `start` that arrives while a transform is in flight is ignored. It produces no extra `done` pulse and does not alter the results of the running transform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a transform on the current inputs |
| in_re | input | 4*DW | Real parts of x0..x3, packed, x0 in the low word |
| in_im | input | 4*DW | Imaginary parts of x0..x3, packed |
| done | output | 1 | One-cycle pulse when new bins are on the outputs |
| out_re | output | 4*(DW+2) | Real parts of bins 0..3, packed |
| out_im | output | 4*(DW+2) | Imaginary parts of bins 0..3, packed |

## Verification
Three registers lie between a stimulus and its result: the input capture, stage one and stage two. The bins and `done` therefore appear just after the third rising edge, counting the edge that accepts `start`. The bench samples on the falling edge in that cycle, checks that `done` is still low one cycle earlier, and checks that it has fallen one cycle later. Tests of hold behaviour and of ignored restarts keep sampling on falling edges for several cycles after the stimulus. They confirm that the outputs keep the earlier results and that no further `done` pulse appears.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

  localparam int unsigned NPTS = 4;
  localparam int unsigned NSTG = 2;

  typedef enum logic [0:0] {
    TW_ONE   = 1'b0,
    TW_NEG_J = 1'b1
  } tw_sel_e;

  // reverse the low 'bits' bits of v
  function automatic int unsigned bitrev(int unsigned v, int unsigned bits);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < bits; i++) begin
      r = (r << 1) | ((v >> i) & 1);
    end
    return r;
  endfunction

  // twiddle used by butterfly idx of stage stg (0-based)
  function automatic tw_sel_e stage_tw(int unsigned stg, int unsigned idx);
    if (stg == 0) return TW_ONE;
    if (idx == 0) return TW_ONE;
    return TW_NEG_J;
  endfunction

  // scaled cosine part of the twiddle
  function automatic int tw_cos(tw_sel_e t, int unsigned s);
    if (t == TW_ONE) return (1 << s);
    return 0;
  endfunction

  // scaled sine part of the twiddle (W = cos + j*sin)
  function automatic int tw_sin(tw_sel_e t, int unsigned s);
    if (t == TW_NEG_J) return -(1 << s);
    return 0;
  endfunction

endpackage

// File: rtl/fft4_cmul.sv
module fft4_cmul
  import fft4_pkg::*;
#(
  parameter int unsigned W      = 12,
  parameter int unsigned S      = 14,
  parameter tw_sel_e     TW     = TW_ONE,
  parameter bit          BYPASS = 1'b1
) (
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic signed [W:0]   m_re,
  output logic signed [W:0]   m_im
);

  generate
    if (BYPASS) begin : g_shortcut
      if (TW == TW_ONE) begin : g_one
        assign m_re = {b_re[W-1], b_re};
        assign m_im = {b_im[W-1], b_im};
      end else begin : g_negj
        // -j*(br + j*bi) = bi - j*br
        logic signed [W:0] br_x;
        assign br_x = {b_re[W-1], b_re};
        assign m_re = {b_im[W-1], b_im};
        assign m_im = -br_x;
      end
    end else begin : g_mult
      localparam int unsigned TWW = S + 2;
      localparam int unsigned PW  = W + TWW;
      localparam logic signed [TWW-1:0] K_C = TWW'(tw_cos(TW, S));
      localparam logic signed [TWW-1:0] K_S = TWW'(tw_sin(TW, S));

      logic signed [PW-1:0] br_x, bi_x, kc_x, ks_x;
      logic signed [PW-1:0] pr, pi, pr_s, pi_s;

      always_comb begin
        br_x = PW'(b_re);
        bi_x = PW'(b_im);
        kc_x = PW'(K_C);
        ks_x = PW'(K_S);
        pr   = br_x * kc_x - bi_x * ks_x;
        pi   = br_x * ks_x + bi_x * kc_x;
        pr_s = pr >>> S;
        pi_s = pi >>> S;
      end

      assign m_re = pr_s[W:0];
      assign m_im = pi_s[W:0];
    end
  endgenerate

endmodule

// File: rtl/fft4_bfly.sv
module fft4_bfly
  import fft4_pkg::*;
#(
  parameter int unsigned W      = 12,
  parameter int unsigned S      = 14,
  parameter tw_sel_e     TW     = TW_ONE,
  parameter bit          BYPASS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic signed [W:0]   c_re,
  output logic signed [W:0]   c_im,
  output logic signed [W:0]   d_re,
  output logic signed [W:0]   d_im
);

  logic signed [W:0] m_re, m_im;
  logic signed [W:0] ax_re, ax_im;
  logic signed [W:0] c_re_d, c_im_d, d_re_d, d_im_d;

  fft4_cmul #(
    .W      (W),
    .S      (S),
    .TW     (TW),
    .BYPASS (BYPASS)
  ) u_mul (
    .b_re (b_re),
    .b_im (b_im),
    .m_re (m_re),
    .m_im (m_im)
  );

  always_comb begin
    ax_re  = {a_re[W-1], a_re};
    ax_im  = {a_im[W-1], a_im};
    c_re_d = c_re;
    c_im_d = c_im;
    d_re_d = d_re;
    d_im_d = d_im;
    if (en) begin
      c_re_d = ax_re + m_re;
      c_im_d = ax_im + m_im;
      d_re_d = ax_re - m_re;
      d_im_d = ax_im - m_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_re <= '0;
      c_im <= '0;
      d_re <= '0;
      d_im <= '0;
    end else begin
      c_re <= c_re_d;
      c_im <= c_im_d;
      d_re <= d_re_d;
      d_im <= d_im_d;
    end
  end

endmodule

// File: rtl/fft4_ctrl.sv
module fft4_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ld_in,
  output logic ld_s1,
  output logic ld_out,
  output logic busy,
  output logic done
);

  logic ph1_q, ph2_q, done_q;
  logic ph1_d, ph2_d, done_d;

  always_comb begin
    busy   = ph1_q | ph2_q;
    ld_in  = start & ~busy;
    ld_s1  = ph1_q;
    ld_out = ph2_q;
    ph1_d  = ld_in;
    ph2_d  = ph1_q;
    done_d = ph2_q;
    done   = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_q  <= 1'b0;
      ph2_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph1_q  <= ph1_d;
      ph2_q  <= ph2_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/fft4_dit.sv
module fft4_dit
  import fft4_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter int unsigned TW_FRAC   = 14,
  parameter bit          TW_BYPASS = 1'b1,
  localparam int unsigned OW       = DW + NSTG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NPTS-1:0][DW-1:0] in_re,
  input  logic [NPTS-1:0][DW-1:0] in_im,
  output logic                    done,
  output logic [NPTS-1:0][OW-1:0] out_re,
  output logic [NPTS-1:0][OW-1:0] out_im
);

  localparam int unsigned IDXW = $clog2(NPTS);
  localparam int unsigned HALF = NPTS / 2;
  localparam int unsigned S1W  = DW + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // sequencing
  logic ld_in, ld_s1, ld_out, busy;

  fft4_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .ld_in  (ld_in),
    .ld_s1  (ld_s1),
    .ld_out (ld_out),
    .busy   (busy),
    .done   (done)
  );

  // input capture in bit-reversed order
  logic signed [DW-1:0] xr_q [NPTS];
  logic signed [DW-1:0] xi_q [NPTS];
  logic signed [DW-1:0] xr_d [NPTS];
  logic signed [DW-1:0] xi_d [NPTS];

  generate
    for (genvar k = 0; k < NPTS; k++) begin : g_cap
      localparam int unsigned SRC = bitrev(k, IDXW);
      always_comb begin
        xr_d[k] = ld_in ? $signed(in_re[SRC]) : xr_q[k];
        xi_d[k] = ld_in ? $signed(in_im[SRC]) : xi_q[k];
      end
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          xr_q[k] <= '0;
          xi_q[k] <= '0;
        end else begin
          xr_q[k] <= xr_d[k];
          xi_q[k] <= xi_d[k];
        end
      end
    end
  endgenerate

  // stage one: adjacent pairs of the reordered inputs
  logic signed [S1W-1:0] s_re [NPTS];
  logic signed [S1W-1:0] s_im [NPTS];

  generate
    for (genvar b = 0; b < HALF; b++) begin : g_st1
      fft4_bfly #(
        .W      (DW),
        .S      (TW_FRAC),
        .TW     (stage_tw(0, b)),
        .BYPASS (TW_BYPASS)
      ) u_bf (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (ld_s1),
        .a_re  (xr_q[2*b]),
        .a_im  (xi_q[2*b]),
        .b_re  (xr_q[2*b+1]),
        .b_im  (xi_q[2*b+1]),
        .c_re  (s_re[2*b]),
        .c_im  (s_im[2*b]),
        .d_re  (s_re[2*b+1]),
        .d_im  (s_im[2*b+1])
      );
    end
  endgenerate

  // stage two: pairs spaced by half, twiddles 1 and -j
  logic signed [OW-1:0] y_re [NPTS];
  logic signed [OW-1:0] y_im [NPTS];

  generate
    for (genvar b = 0; b < HALF; b++) begin : g_st2
      fft4_bfly #(
        .W      (S1W),
        .S      (TW_FRAC),
        .TW     (stage_tw(1, b)),
        .BYPASS (TW_BYPASS)
      ) u_bf (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (ld_out),
        .a_re  (s_re[b]),
        .a_im  (s_im[b]),
        .b_re  (s_re[b+HALF]),
        .b_im  (s_im[b+HALF]),
        .c_re  (y_re[b]),
        .c_im  (y_im[b]),
        .d_re  (y_re[b+HALF]),
        .d_im  (y_im[b+HALF])
      );
    end
    for (genvar k = 0; k < NPTS; k++) begin : g_out
      assign out_re[k] = y_re[k];
      assign out_im[k] = y_im[k];
    end
  endgenerate

endmodule

// File: rtl/fft4_dit_chk.sv
module fft4_dit_chk #(
  parameter int unsigned DW = 12,
  localparam int unsigned OW = DW + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [3:0][DW-1:0] in_re,
  input logic [3:0][DW-1:0] in_im,
  input logic [3:0][OW-1:0] out_re,
  input logic [3:0][OW-1:0] out_im
);

  function automatic logic signed [OW-1:0] sx(logic [DW-1:0] v);
    return OW'($signed(v));
  endfunction

  logic signed [OW-1:0] dc_re, dc_im, alt_re, alt_im;

  always_comb begin
    dc_re  = sx(in_re[0]) + sx(in_re[1]) + sx(in_re[2]) + sx(in_re[3]);
    dc_im  = sx(in_im[0]) + sx(in_im[1]) + sx(in_im[2]) + sx(in_im[3]);
    alt_re = sx(in_re[0]) - sx(in_re[1]) + sx(in_re[2]) - sx(in_re[3]);
    alt_im = sx(in_im[0]) - sx(in_im[1]) + sx(in_im[2]) - sx(in_im[3]);
  end

  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> ##3 done);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_dc_bin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(out_re[0]) == $past(dc_re, 3) &&
              $signed(out_im[0]) == $past(dc_im, 3)));

  a_r4_alt_bin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(out_re[2]) == $past(alt_re, 3) &&
              $signed(out_im[2]) == $past(alt_im, 3)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_re) && $stable(out_im)));

  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> ##3 !done);

endmodule

bind fft4_dit fft4_dit_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .in_re  (in_re),
  .in_im  (in_im),
  .out_re (out_re),
  .out_im (out_im)
);

// File: tb/sim_fft4_dit.sv
`timescale 1ns/1ps
module sim_fft4_dit;

  localparam int DW = 12;
  localparam int OW = DW + 2;
  localparam int NV = 6;

  // each row: x0r x0i x1r x1i x2r x2i x3r x3i
  localparam int VEC [NV][8] = '{
    '{ 100,    0,    0,    0,    0,    0,    0,    0},
    '{   5,   -3,    5,   -3,    5,   -3,    5,   -3},
    '{ 300,  -40, -300,   40,  300,  -40, -300,   40},
    '{   0,    0,    7,    9,    0,    0,    0,    0},
    '{ 123, -456,  789, -321,  -55,  999, -1000, 17},
    '{   0,    0,    0,    0,    0,    0,    0, -700}
  };

  logic clk, rst_n, start, done;
  logic [3:0][DW-1:0] in_re, in_im;
  logic [3:0][OW-1:0] out_re, out_im;

  int n_run, n_fail;
  bit finished;

  fft4_dit u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .in_re  (in_re),
    .in_im  (in_im),
    .done   (done),
    .out_re (out_re),
    .out_im (out_im)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int d [8]);
    for (int k = 0; k < 4; k++) begin
      in_re[k] = DW'(d[2*k]);
      in_im[k] = DW'(d[2*k+1]);
    end
  endtask

  // expected bins from the requirement formulas: e = X0r X0i X1r X1i X2r X2i X3r X3i
  task automatic model(input int d [8], output int e [8]);
    e[0] = d[0] + d[2] + d[4] + d[6];
    e[1] = d[1] + d[3] + d[5] + d[7];
    e[2] = d[0] - d[4] + d[3] - d[7];
    e[3] = d[1] - d[5] - d[2] + d[6];
    e[4] = d[0] - d[2] + d[4] - d[6];
    e[5] = d[1] - d[3] + d[5] - d[7];
    e[6] = d[0] - d[4] - d[3] + d[7];
    e[7] = d[1] - d[5] + d[2] - d[6];
  endtask

  task automatic check_bins(input int e [8], input string tag);
    string rq;
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: rq = "R3";
        1: rq = "R5";
        2: rq = "R4";
        default: rq = "R6";
      endcase
      chk(rq, $sformatf("%s bin%0d re", tag, k), int'($signed(out_re[k])), e[2*k]);
      chk(rq, $sformatf("%s bin%0d im", tag, k), int'($signed(out_im[k])), e[2*k+1]);
    end
  endtask

  // one transform: start is sampled at edge E0, done is visible after E2
  task automatic run_vec(input int d [8], input string tag);
    int e [8];
    model(d, e);
    @(negedge clk);
    drive(d);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", {tag, " done early"}, int'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2", {tag, " done due"}, int'(done), 1);
    check_bins(e, tag);
    @(posedge clk);
    @(negedge clk);
    chk("R2", {tag, " done one cycle"}, int'(done), 0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int e [8];
    int e2 [8];
    int fa [8];
    int fb [8];
    int fz [8];
    n_run = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    in_re = '0;
    in_im = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "bins in reset", int'(|{out_re, out_im}), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "done after release", int'(done), 0);
    chk("R1", "bins after release", int'(|{out_re, out_im}), 0);

    // table of stimulus vectors, expected bins computed by model
    for (int v = 0; v < NV; v++) begin
      run_vec(VEC[v], $sformatf("vec%0d", v));
    end

    // R7: full-scale corners
    fz = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
    model(fz, e);
    run_vec(fz, "allmin");
    chk("R7", "allmin bin0 re", int'($signed(out_re[0])), -8192);
    chk("R7", "allmin bin0 im", int'($signed(out_im[0])), e[1]);
    fa = '{2047, 0, 0, 2047, -2048, 0, 0, -2048};
    run_vec(fa, "maxpos");
    chk("R7", "maxpos bin1 re", int'($signed(out_re[1])), 8190);
    fb = '{-2048, 2047, -2048, -2048, 2047, 0, 0, 2047};
    model(fb, e2);
    run_vec(fb, "negj");
    chk("R7", "negj bin1 re", int'($signed(out_re[1])), -8190);
    chk("R7", "negj bin3 im", int'($signed(out_im[3])), e2[7]);

    // R8: inputs change without start, results hold
    @(negedge clk);
    drive(VEC[4]);
    repeat (5) @(negedge clk);
    chk("R8", "done stays low", int'(done), 0);
    check_bins(e2, "R8 hold");
    chk("R8", "hold bin1 re", int'($signed(out_re[1])), e2[2]);

    // R9: restart while busy is ignored
    model(VEC[2], e);
    @(negedge clk);
    drive(VEC[2]);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(VEC[4]);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done early", int'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "done for first", int'(done), 1);
    chk("R9", "first bin1 re", int'($signed(out_re[1])), e[2]);
    chk("R9", "first bin0 re", int'($signed(out_re[0])), e[0]);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "no second done a", int'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "no second done b", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R9", "results kept", int'($signed(out_re[1])), e[2]);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule